// File: doc/BRIEF.md
# Core Idle-Depth Sequencer

This block steps one processor core between normal operation and three progressively deeper idle levels. A level is requested on a 2-bit input. Each level takes every action of the shallower levels and adds its own. The actions always run in the same order: stop the core clock, flush the first-level cache, switch the PLL off, flush the second-level cache, then remove power from both caches. Each flush is a request/done handshake with the cache, so the sequencer waits for the cache before it moves on. The PLL and the cache power rails are modelled as enable outputs only.

A wake input leaves an idle level, and it also cancels an entry that is still in progress. Exit undoes the actions that were actually taken, in reverse order. It first waits a delay that grows with the depth that was reached. It then restores cache power, then re-enables the PLL and waits a lock count, and only after that does it release the core clock. A 2-bit level indicator changes only when a sequence has fully completed.

States: RUN (clock running, level 0), GATE (clock stopped), L1FL (first-level flush handshake), PLLOFF (PLL disabled), L2FL (second-level flush handshake), PWROFF (cache power removed), SLEEP (resting at the requested depth), WAKE (depth-dependent wake delay), PWRON (cache power restored), LOCK (PLL lock wait).

Transitions:
- RUN goes to GATE on a nonzero request while wake is low.
- GATE goes to L1FL.
- L1FL goes to SLEEP (light level) or to PLLOFF when first-level done arrives.
- PLLOFF goes to L2FL.
- L2FL goes to SLEEP (deep level) or to PWROFF when second-level done arrives.
- PWROFF goes to SLEEP.
- SLEEP, or any entry state, goes to WAKE on wake.
- WAKE goes to PWRON, LOCK or RUN when the delay expires, according to what was switched off.
- PWRON goes to LOCK.
- LOCK goes to RUN when the lock count expires.

Top module: `cstate_seq`

## Requirements
- R1: Out of reset, core_clk_en, pll_en, l1_pwr_en and l2_pwr_en are 1, both flush requests are 0, and cur_level is 0.
- R2: A request of req_level=1 (light level) first drops core_clk_en for one cycle with no flush request. It then raises l1_flush_req and holds it until l1_flush_done. It then settles with cur_level=1, the PLL enabled and both caches powered.
- R3: A request of req_level=2 (deep level) also does the following after the first-level flush completes. It drops pll_en for one cycle with no flush request. It then raises l2_flush_req until l2_flush_done, and settles with cur_level=2 and both caches powered. At most one flush request is active at any time.
- R4: A request of req_level=3 (off level) also does the following after the second-level flush completes. It drops l1_pwr_en and l2_pwr_en together, then settles with cur_level=3. No cache loses power unless both flush handshakes of this entry have completed.
- R5: req_level=0 means stay active. While running with req_level=0, no output changes.
- R6: Wake from an idle level restores the actions in reverse order: cache power first, then pll_en, then core_clk_en. core_clk_en rises only after pll_en has been high for at least LOCK_CYC cycles. cur_level returns to 0 in the same cycle that core_clk_en rises.
- R7: The number of cycles from wake to core_clk_en rising exceeds WAKE_L1, WAKE_L2 or WAKE_L3 for the light, deep or off level respectively. It is strictly larger for each deeper level.
- R8: A wake during an entry sequence withdraws the pending flush request in the next cycle. It undoes only the actions already taken, and cur_level stays 0 throughout.
- R9: While the block runs, a high wake blocks entry whatever req_level says. While idle, changes of req_level have no effect until wake.
- R10: cur_level stays at its old value until an entry sequence has fully finished, and is never nonzero while a flush request is active or the core clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_level | input | 2 | Requested idle level: 0 run, 1 light, 2 deep, 3 off |
| wake | input | 1 | Wake event; exits or aborts idle entry, blocks entry while high |
| l1_flush_done | input | 1 | First-level cache reports flush finished |
| l2_flush_done | input | 1 | Second-level cache reports flush finished |
| core_clk_en | output | 1 | 1 lets the core clock run |
| pll_en | output | 1 | 1 keeps the PLL running |
| l1_flush_req | output | 1 | Ask the first-level cache to flush |
| l2_flush_req | output | 1 | Ask the second-level cache to flush |
| l1_pwr_en | output | 1 | Power enable of the first-level cache |
| l2_pwr_en | output | 1 | Power enable of the second-level cache |
| cur_level | output | 2 | Settled idle level, same encoding as req_level |

## Verification
The bench exercises the cancellation of an entry at two points: during the first-level flush, and during the second-level flush with the PLL already off. A design that forgot to restore the PLL would then release the clock with pll_en low. A design that kept the flush request up would leave the cache flushing after wake. It compares wake latency across the three depths; a design that used one delay for all would fail the strict ordering. It also counts PLL-on cycles before the clock is released, which catches a design that ungates right after re-enabling the PLL. A held wake with a deep request, and request changes while idle, would show as unexpected output changes in a design that ignored these cases.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

    typedef enum logic [3:0] {
        S_RUN,
        S_GATE,
        S_L1FL,
        S_PLLOFF,
        S_L2FL,
        S_PWROFF,
        S_SLEEP,
        S_WAKE,
        S_PWRON,
        S_LOCK
    } seq_state_t;

    typedef enum logic [1:0] {
        LV_RUN   = 2'd0,
        LV_LIGHT = 2'd1,
        LV_DEEP  = 2'd2,
        LV_OFF   = 2'd3
    } level_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cstate_timer.sv
module cstate_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/cstate_fsm.sv
module cstate_fsm
    import cstate_pkg::*;
#(
    parameter int unsigned WAKE_L1  = 8,
    parameter int unsigned WAKE_L2  = 24,
    parameter int unsigned WAKE_L3  = 64,
    parameter int unsigned LOCK_CYC = 12,
    parameter int unsigned TW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    req_level,
    input  logic          wake,
    input  logic          l1_done,
    input  logic          l2_done,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          core_clk_en,
    output logic          pll_en,
    output logic          l1_flush_req,
    output logic          l2_flush_req,
    output logic          l1_pwr_en,
    output logic          l2_pwr_en,
    output logic [1:0]    cur_level
);
    seq_state_t st, nxt;
    level_t     tgt;
    level_t     cur;
    logic [1:0] reach;
    logic       pll_dn;
    logic       pwr_dn;

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            S_RUN:    if (!wake && req_level != LV_RUN) nxt = S_GATE;
            S_GATE:   nxt = wake ? S_WAKE : S_L1FL;
            S_L1FL: begin
                if (wake)         nxt = S_WAKE;
                else if (l1_done) nxt = (tgt == LV_LIGHT) ? S_SLEEP : S_PLLOFF;
            end
            S_PLLOFF: nxt = wake ? S_WAKE : S_L2FL;
            S_L2FL: begin
                if (wake)         nxt = S_WAKE;
                else if (l2_done) nxt = (tgt == LV_DEEP) ? S_SLEEP : S_PWROFF;
            end
            S_PWROFF: nxt = wake ? S_WAKE : S_SLEEP;
            S_SLEEP:  if (wake) nxt = S_WAKE;
            S_WAKE: begin
                if (tmr_expired) begin
                    if (pwr_dn)      nxt = S_PWRON;
                    else if (pll_dn) nxt = S_LOCK;
                    else             nxt = S_RUN;
                end
            end
            S_PWRON:  nxt = pll_dn ? S_LOCK : S_RUN;
            S_LOCK:   if (tmr_expired) nxt = S_RUN;
            default:  nxt = S_RUN;
        endcase
    end

    // timer load selection: wake delay by depth reached, or PLL lock count
    always_comb begin
        tmr_load = ((nxt == S_WAKE) && (st != S_WAKE)) ||
                   ((nxt == S_LOCK) && (st != S_LOCK));
        if (nxt == S_LOCK) begin
            tmr_val = TW'(LOCK_CYC);
        end else begin
            unique case (reach)
                2'd1:    tmr_val = TW'(WAKE_L1);
                2'd2:    tmr_val = TW'(WAKE_L2);
                default: tmr_val = TW'(WAKE_L3);
            endcase
        end
    end

    // state register and sequencing flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_RUN;
            tgt    <= LV_RUN;
            cur    <= LV_RUN;
            reach  <= 2'd0;
            pll_dn <= 1'b0;
            pwr_dn <= 1'b0;
        end else begin
            st <= nxt;
            if (st == S_RUN && nxt == S_GATE) begin
                tgt   <= level_t'(req_level);
                reach <= 2'd1;
            end
            if (st != S_PLLOFF && nxt == S_PLLOFF) begin
                pll_dn <= 1'b1;
                reach  <= 2'd2;
            end
            if (st != S_PWROFF && nxt == S_PWROFF) begin
                pwr_dn <= 1'b1;
                reach  <= 2'd3;
            end
            if (nxt == S_PWRON) pwr_dn <= 1'b0;
            if (st != S_LOCK && nxt == S_LOCK) pll_dn <= 1'b0;
            if (st != S_SLEEP && nxt == S_SLEEP) cur <= tgt;
            if (st != S_RUN && nxt == S_RUN) begin
                cur   <= LV_RUN;
                reach <= 2'd0;
            end
        end
    end

    // outputs
    always_comb begin
        core_clk_en  = (st == S_RUN);
        pll_en       = !pll_dn;
        l1_pwr_en    = !pwr_dn;
        l2_pwr_en    = !pwr_dn;
        l1_flush_req = (st == S_L1FL);
        l2_flush_req = (st == S_L2FL);
        cur_level    = cur;
    end

    AST_ONE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(l1_flush_req && l2_flush_req)); // R3

    AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && (l1_flush_req || l2_flush_req)) |=> !(l1_flush_req || l2_flush_req)); // R8

endmodule

// File: rtl/cstate_seq.sv
module cstate_seq
    import cstate_pkg::*;
#(
    parameter int unsigned WAKE_L1  = 8,
    parameter int unsigned WAKE_L2  = 24,
    parameter int unsigned WAKE_L3  = 64,
    parameter int unsigned LOCK_CYC = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_level,
    input  logic       wake,
    input  logic       l1_flush_done,
    input  logic       l2_flush_done,
    output logic       core_clk_en,
    output logic       pll_en,
    output logic       l1_flush_req,
    output logic       l2_flush_req,
    output logic       l1_pwr_en,
    output logic       l2_pwr_en,
    output logic [1:0] cur_level
);
    localparam int unsigned TMAX = max3(WAKE_L3, LOCK_CYC, max3(WAKE_L1, WAKE_L2, 1));
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned LW   = $clog2(LOCK_CYC + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;

    cstate_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    cstate_fsm #(
        .WAKE_L1  (WAKE_L1),
        .WAKE_L2  (WAKE_L2),
        .WAKE_L3  (WAKE_L3),
        .LOCK_CYC (LOCK_CYC),
        .TW       (TW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_level    (req_level),
        .wake         (wake),
        .l1_done      (l1_flush_done),
        .l2_done      (l2_flush_done),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .core_clk_en  (core_clk_en),
        .pll_en       (pll_en),
        .l1_flush_req (l1_flush_req),
        .l2_flush_req (l2_flush_req),
        .l1_pwr_en    (l1_pwr_en),
        .l2_pwr_en    (l2_pwr_en),
        .cur_level    (cur_level)
    );

    // observation state for assertions: flush completion and PLL-on time
    logic          l1_clean, l2_clean;
    logic [LW-1:0] pll_on_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l1_clean   <= 1'b0;
            l2_clean   <= 1'b0;
            pll_on_cnt <= LW'(LOCK_CYC);
        end else begin
            if (core_clk_en) begin
                l1_clean <= 1'b0;
                l2_clean <= 1'b0;
            end else begin
                if (l1_flush_req && l1_flush_done) l1_clean <= 1'b1;
                if (l2_flush_req && l2_flush_done) l2_clean <= 1'b1;
            end
            if (!pll_en)                        pll_on_cnt <= '0;
            else if (pll_on_cnt < LW'(LOCK_CYC)) pll_on_cnt <= pll_on_cnt + 1'b1;
        end
    end

    AST_GATE_BEFORE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_flush_req || l2_flush_req) |-> !core_clk_en); // R2

    AST_L2_AFTER_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        l2_flush_req |-> !pll_en); // R3

    AST_PWR_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(l1_pwr_en) || $fell(l2_pwr_en)) |-> (l1_clean && l2_clean)); // R4

    AST_PLL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> !core_clk_en); // R6

    AST_UNGATE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (pll_en && pll_on_cnt >= LW'(LOCK_CYC))); // R6

    AST_LEVEL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level != 2'd0) |-> (!l1_flush_req && !l2_flush_req && !core_clk_en)); // R10

endmodule

// File: tb/cstate_seq_tb_top.sv
`timescale 1ns/1ps
module cstate_seq_tb_top;
    localparam int unsigned WL1 = 8;
    localparam int unsigned WL2 = 24;
    localparam int unsigned WL3 = 64;
    localparam int unsigned LCK = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_level = 2'd0;
    logic       wake = 1'b0;
    logic       l1_flush_done = 1'b0;
    logic       l2_flush_done = 1'b0;
    logic       core_clk_en, pll_en, l1_flush_req, l2_flush_req, l1_pwr_en, l2_pwr_en;
    logic [1:0] cur_level;

    always #10 clk = ~clk;

    cstate_seq #(.WAKE_L1(WL1), .WAKE_L2(WL2), .WAKE_L3(WL3), .LOCK_CYC(LCK)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_level(req_level), .wake(wake),
        .l1_flush_done(l1_flush_done), .l2_flush_done(l2_flush_done),
        .core_clk_en(core_clk_en), .pll_en(pll_en),
        .l1_flush_req(l1_flush_req), .l2_flush_req(l2_flush_req),
        .l1_pwr_en(l1_pwr_en), .l2_pwr_en(l2_pwr_en), .cur_level(cur_level)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct { logic [7:0] v; string tag; } item_t;
    item_t exp_q[$];

    function automatic logic [7:0] outvec();
        return {core_clk_en, pll_en, l1_pwr_en, l2_pwr_en,
                l1_flush_req, l2_flush_req, cur_level};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] v, input string tag);
        item_t it;
        it.v = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // cache flush responders
    int l1_dly = 3, l2_dly = 4, l1_cnt = 0, l2_cnt = 0;
    always @(negedge clk) begin
        if (l1_flush_req) begin l1_cnt++; l1_flush_done = (l1_cnt == l1_dly); end
        else begin l1_cnt = 0; l1_flush_done = 1'b0; end
        if (l2_flush_req) begin l2_cnt++; l2_flush_done = (l2_cnt == l2_dly); end
        else begin l2_cnt = 0; l2_flush_done = 1'b0; end
    end

    // PLL-on-while-gated counter
    int pll_gated = 0;
    always @(negedge clk) begin
        if (!pll_en) pll_gated = 0;
        else if (!core_clk_en) pll_gated++;
    end

    // monitor: every output change is compared against the scoreboard
    logic [7:0] last_v = 8'hF0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] v;
            v = outvec();
            if (v != last_v) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected change (R5/R9)", int'(v), int'(last_v));
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(v == it.v, it.tag, int'(v), int'(it.v));
                end
                last_v = v;
            end
        end
    end

    task automatic wait_level(input logic [1:0] lv, input string req);
        int n = 0;
        while (cur_level != lv && n < 2000) begin @(negedge clk); n++; end
        check(cur_level == lv, req, int'(cur_level), int'(lv));
    endtask

    task automatic do_wake(output int lat);
        int n = 0;
        req_level = 2'd0;
        wake = 1'b1;
        while (!core_clk_en && n < 5000) begin @(negedge clk); n++; end
        wake = 1'b0;
        lat = n;
    endtask

    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        int lat1, lat2, lat3, latx;
        repeat (4) @(negedge clk);
        check(outvec() == 8'hF0, "R1 reset outputs", int'(outvec()), 8'hF0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(outvec() == 8'hF0, "R5 idle run with req 0", int'(outvec()), 8'hF0);

        // light level
        push(8'b0111_0000, "R2 clock gated first");
        push(8'b0111_1000, "R2 L1 flush request");
        push(8'b0111_0001, "R2 settled at level 1 (R10)");
        req_level = 2'd1;
        wait_level(2'd1, "R2 reaches level 1");
        req_level = 2'd3;
        repeat (10) @(negedge clk);
        check(cur_level == 2'd1, "R9 request ignored while idle", int'(cur_level), 1);
        push(8'b1111_0000, "R6 light wake to run");
        do_wake(lat1);
        check(pll_gated >= LCK, "R6 PLL time before ungate", pll_gated, LCK);
        check(lat1 > WL1, "R7 light wake latency", lat1, WL1 + 1);
        drain("R2 light sequence complete");

        // deep level
        push(8'b0111_0000, "R3 clock gated");
        push(8'b0111_1000, "R3 L1 flush");
        push(8'b0011_0000, "R3 PLL off after L1 flush");
        push(8'b0011_0100, "R3 L2 flush");
        push(8'b0011_0010, "R3 settled at level 2 (R10)");
        req_level = 2'd2;
        wait_level(2'd2, "R3 reaches level 2");
        req_level = 2'd0;
        repeat (10) @(negedge clk);
        check(cur_level == 2'd2, "R9 req 0 ignored while idle", int'(cur_level), 2);
        push(8'b0111_0010, "R6 PLL back on before clock");
        push(8'b1111_0000, "R6 deep wake to run");
        do_wake(lat2);
        check(pll_gated >= LCK, "R6 lock wait deep", pll_gated, LCK);
        check(lat2 > WL2, "R7 deep wake latency", lat2, WL2 + 1);
        drain("R3 deep sequence complete");

        // off level
        push(8'b0111_0000, "R4 clock gated");
        push(8'b0111_1000, "R4 L1 flush");
        push(8'b0011_0000, "R4 PLL off");
        push(8'b0011_0100, "R4 L2 flush");
        push(8'b0000_0000, "R4 caches powered off");
        push(8'b0000_0011, "R4 settled at level 3 (R10)");
        req_level = 2'd3;
        wait_level(2'd3, "R4 reaches level 3");
        push(8'b0011_0011, "R6 cache power first");
        push(8'b0111_0011, "R6 PLL second");
        push(8'b1111_0000, "R6 clock last");
        do_wake(lat3);
        check(pll_gated >= LCK, "R6 lock wait off", pll_gated, LCK);
        check(lat3 > WL3, "R7 off wake latency", lat3, WL3 + 1);
        check(lat1 < lat2, "R7 deep slower than light", lat2, lat1 + 1);
        check(lat2 < lat3, "R7 off slower than deep", lat3, lat2 + 1);
        drain("R4 off sequence complete");

        // wake held while running blocks entry
        wake = 1'b1;
        req_level = 2'd3;
        repeat (20) @(negedge clk);
        check(outvec() == 8'hF0, "R9 wake blocks entry", int'(outvec()), 8'hF0);
        wake = 1'b0;
        req_level = 2'd0;
        @(negedge clk);

        // abort during L1 flush
        l1_dly = 1000;
        push(8'b0111_0000, "R8 gated");
        push(8'b0111_1000, "R8 L1 flush pending");
        push(8'b0111_0000, "R8 flush withdrawn, level stays 0");
        push(8'b1111_0000, "R8 clock restored");
        req_level = 2'd2;
        while (!l1_flush_req) @(negedge clk);
        repeat (3) @(negedge clk);
        do_wake(latx);
        drain("R8 abort in L1 flush");

        // abort during L2 flush with PLL already off
        l1_dly = 2;
        l2_dly = 1000;
        push(8'b0111_0000, "R8 gated");
        push(8'b0111_1000, "R8 L1 flush");
        push(8'b0011_0000, "R8 PLL off");
        push(8'b0011_0100, "R8 L2 flush pending");
        push(8'b0011_0000, "R8 L2 flush withdrawn");
        push(8'b0111_0000, "R8 PLL restored before clock");
        push(8'b1111_0000, "R8 clock restored");
        req_level = 2'd3;
        while (!l2_flush_req) @(negedge clk);
        repeat (3) @(negedge clk);
        do_wake(latx);
        check(pll_gated >= LCK, "R8 lock wait after abort", pll_gated, LCK);
        drain("R8 abort in L2 flush");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule